// File: doc/BRIEF.md
# Slowdown-Balancing DRAM Request Arbiter

This block chooses one request per cycle from a small buffer of pending DRAM requests that several hardware threads share. Every buffer slot carries a valid flag, the issuing thread, the target bank, the target row and an age value, where a larger age marks a request that has waited longer. The arbiter also sees which row is currently open in each bank, so it can tell row hits from row misses.

For every thread, the arbiter counts the cycles in which that thread stalls on DRAM while it has work queued. It also receives an outside estimate of how long the thread would have stalled with the memory system to itself. The ratio of the two is the thread's slowdown. Among the threads that have a request queued, the spread between the largest and the smallest slowdown is compared every cycle against a programmable threshold. While that spread stays below the threshold, the arbiter favours row hits to keep throughput high. Once the spread reaches the threshold, the most slowed-down thread goes to the front of the line.

Top module: `fair_dram_arbiter`

## Requirements
- R1: `gnt_valid` is high in exactly the cycles where at least one `req_valid` bit is set, and `gnt_idx` then names a valid slot. With an empty buffer, `gnt_valid` is low.
- R2: A thread's shared-stall counter rises by one at a clock edge only when that thread's `thread_stall` bit is high and a valid slot carries its id. Stall cycles without a queued request are not counted.
- R3: Only threads that have a valid slot take part in the largest/smallest slowdown search, and `top_thread` is always one of them.
- R4: In throughput mode (`fair_mode` low), a slot whose row equals the open row of its bank beats any miss, and among equals the larger age wins.
- R5: In fairness mode (`fair_mode` high), slots of `top_thread` come first, then row hits, then the larger age.
- R6: Slowdown order is decided by cross products: thread a is slower than thread b when shared_a·alone_b > shared_b·alone_a. `fair_mode` is high when max_shared·min_alone·2^THR_FRAC ≥ `unfair_thresh`·max_alone·min_shared and max_shared is nonzero. `unfair_thresh` is unsigned fixed point with THR_FRAC (default 4) fraction bits.
- R7: An alone-stall estimate of zero is used as one.
- R8: Remaining ties go to the lowest slot index. For `top_thread`, and for the smallest-slowdown thread, ties go to the lowest thread id. `top_thread` is 0 when no thread is active.
- R9: Mode, `top_thread` and grant follow the current inputs within the same cycle, using counters that hold the stalls counted up to the previous edge.
- R10: While `rst_n` is low, every shared-stall counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | BUF_DEPTH | Slot occupied flags |
| req_thread | input | BUF_DEPTH*TID_W | Thread id per slot |
| req_bank | input | BUF_DEPTH*BANK_W | Bank per slot |
| req_row | input | BUF_DEPTH*ROW_W | Row per slot |
| req_age | input | BUF_DEPTH*AGE_W | Waiting age per slot, larger is older |
| open_row | input | NUM_BANKS*ROW_W | Currently open row per bank |
| thread_stall | input | NUM_THREADS | Thread is stalled on DRAM this cycle |
| alone_est | input | NUM_THREADS*ALONE_W | Estimated alone-mode stall time per thread |
| unfair_thresh | input | THR_W | Unfairness threshold, fixed point |
| gnt_valid | output | 1 | A slot is granted |
| gnt_idx | output | IDX_W | Granted slot |
| fair_mode | output | 1 | Fairness ordering is active |
| top_thread | output | TID_W | Active thread with the largest slowdown |

## Verification
The bench targets the exact-threshold boundary, where a ratio equal to the threshold must select fairness mode. A strict compare there would keep favouring hits. Stalls raised by a thread with nothing queued must leave its counter untouched, or that thread would later take over `top_thread` wrongly. A zero alone estimate must act as one rather than as an infinite slowdown, which would make the wrong thread the slowest. Threads with a large slowdown but no queued request must drop out of the search, and equal keys must resolve to the lowest slot, so a design with reversed tie-breaking or stale counters after reset grants a different slot than the bench expects.

// File: rtl/fda_pkg.sv
package fda_pkg;
   typedef enum logic {
      FDA_THROUGHPUT = 1'b0,
      FDA_FAIRNESS   = 1'b1
   } fda_mode_e;
endpackage

// File: rtl/fda_stall_tracker.sv
module fda_stall_tracker #(
   parameter int NUM_THREADS = 4,
   parameter int STALL_W     = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_THREADS-1:0]         stall,
   input  logic [NUM_THREADS-1:0]         active,
   output logic [NUM_THREADS*STALL_W-1:0] shared_flat
);
   generate
      for (genvar g = 0; g < NUM_THREADS; g++) begin : g_cnt
         logic [STALL_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (stall[g] && active[g] && (cnt != {STALL_W{1'b1}}))
               cnt <= cnt + STALL_W'(1);
         end
         assign shared_flat[g*STALL_W +: STALL_W] = cnt;
      end
   endgenerate
endmodule

// File: rtl/fda_slowdown_cmp.sv
module fda_slowdown_cmp
   import fda_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int STALL_W     = 16,
   parameter int ALONE_W     = 12,
   parameter int THR_W       = 8,
   parameter int THR_FRAC    = 4,
   localparam int TID_W      = $clog2(NUM_THREADS)
) (
   input  logic [NUM_THREADS*STALL_W-1:0] shared_flat,
   input  logic [NUM_THREADS*ALONE_W-1:0] alone_flat,
   input  logic [NUM_THREADS-1:0]         active,
   input  logic [THR_W-1:0]               thresh,
   output fda_mode_e                      mode,
   output logic [TID_W-1:0]               top_thread
);
   localparam int PAIR_W = STALL_W + ALONE_W;
   localparam int CMP_W  = PAIR_W + THR_W;

   generate
      if (THR_FRAC > THR_W) begin : g_bad_frac
         $error("fda_slowdown_cmp: THR_FRAC must not exceed THR_W");
      end
   endgenerate

   logic [STALL_W-1:0] sh [NUM_THREADS];
   logic [ALONE_W-1:0] al [NUM_THREADS];

   generate
      for (genvar g = 0; g < NUM_THREADS; g++) begin : g_unpack
         assign sh[g] = shared_flat[g*STALL_W +: STALL_W];
         assign al[g] = (alone_flat[g*ALONE_W +: ALONE_W] == '0) ?
                        ALONE_W'(1) : alone_flat[g*ALONE_W +: ALONE_W];
      end
   endgenerate

   function automatic logic [PAIR_W-1:0] xmul(input logic [STALL_W-1:0] s,
                                               input logic [ALONE_W-1:0] a);
      return PAIR_W'(s) * PAIR_W'(a);
   endfunction

   logic             found;
   logic [TID_W-1:0] mx, mn;
   logic [CMP_W-1:0] lhs, rhs;

   always_comb begin
      found = 1'b0;
      mx    = '0;
      mn    = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         if (active[t]) begin
            if (!found) begin
               found = 1'b1;
               mx    = TID_W'(t);
               mn    = TID_W'(t);
            end else begin
               if (xmul(sh[t], al[mx]) > xmul(sh[mx], al[t])) mx = TID_W'(t);
               if (xmul(sh[t], al[mn]) < xmul(sh[mn], al[t])) mn = TID_W'(t);
            end
         end
      end
      lhs  = CMP_W'(xmul(sh[mx], al[mn])) << THR_FRAC;
      rhs  = CMP_W'(thresh) * CMP_W'(al[mx]) * CMP_W'(sh[mn]);
      mode = (found && (sh[mx] != '0) && (lhs >= rhs)) ? FDA_FAIRNESS : FDA_THROUGHPUT;
      top_thread = mx;
   end
endmodule

// File: rtl/fda_grant_select.sv
module fda_grant_select #(
   parameter int DEPTH   = 8,
   parameter int AGE_W   = 8,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int KEY_W  = AGE_W + 2
) (
   input  logic [DEPTH-1:0]       valid,
   input  logic [DEPTH-1:0]       pri,
   input  logic [DEPTH-1:0]       hit,
   input  logic [DEPTH*AGE_W-1:0] age_flat,
   output logic                   gnt_valid,
   output logic [IDX_W-1:0]       gnt_idx
);
   logic [KEY_W-1:0] key [DEPTH];
   logic [KEY_W-1:0] best;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_key
         assign key[g] = {pri[g], hit[g], age_flat[g*AGE_W +: AGE_W]};
      end
   endgenerate

   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      best      = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (valid[i] && (!gnt_valid || (key[i] > best))) begin
            gnt_valid = 1'b1;
            gnt_idx   = IDX_W'(i);
            best      = key[i];
         end
      end
   end
endmodule

// File: rtl/fair_dram_arbiter.sv
module fair_dram_arbiter
   import fda_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int BUF_DEPTH   = 8,
   parameter int NUM_BANKS   = 4,
   parameter int ROW_W       = 8,
   parameter int AGE_W       = 8,
   parameter int STALL_W     = 16,
   parameter int ALONE_W     = 12,
   parameter int THR_W       = 8,
   parameter int THR_FRAC    = 4,
   localparam int TID_W      = $clog2(NUM_THREADS),
   localparam int IDX_W      = $clog2(BUF_DEPTH),
   localparam int BANK_W     = $clog2(NUM_BANKS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [BUF_DEPTH-1:0]           req_valid,
   input  logic [BUF_DEPTH*TID_W-1:0]     req_thread,
   input  logic [BUF_DEPTH*BANK_W-1:0]    req_bank,
   input  logic [BUF_DEPTH*ROW_W-1:0]     req_row,
   input  logic [BUF_DEPTH*AGE_W-1:0]     req_age,
   input  logic [NUM_BANKS*ROW_W-1:0]     open_row,
   input  logic [NUM_THREADS-1:0]         thread_stall,
   input  logic [NUM_THREADS*ALONE_W-1:0] alone_est,
   input  logic [THR_W-1:0]               unfair_thresh,
   output logic                           gnt_valid,
   output logic [IDX_W-1:0]               gnt_idx,
   output logic                           fair_mode,
   output logic [TID_W-1:0]               top_thread
);
   generate
      if (NUM_THREADS < 2 || (1 << TID_W) != NUM_THREADS) begin : g_bad_thr
         $error("fair_dram_arbiter: NUM_THREADS must be a power of two, at least 2");
      end
      if (BUF_DEPTH < 2) begin : g_bad_depth
         $error("fair_dram_arbiter: BUF_DEPTH must be at least 2");
      end
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_bank
         $error("fair_dram_arbiter: NUM_BANKS must be a power of two, at least 2");
      end
   endgenerate

   logic [NUM_THREADS-1:0]         active;
   logic [BUF_DEPTH-1:0]           hit;
   logic [BUF_DEPTH-1:0]           pri;
   logic [NUM_THREADS*STALL_W-1:0] shared_flat;
   logic [ROW_W-1:0]               bank_row [NUM_BANKS];
   fda_mode_e                      mode;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign bank_row[b] = open_row[b*ROW_W +: ROW_W];
      end
      for (genvar e = 0; e < BUF_DEPTH; e++) begin : g_entry
         assign hit[e] = req_row[e*ROW_W +: ROW_W] == bank_row[req_bank[e*BANK_W +: BANK_W]];
         assign pri[e] = (mode == FDA_FAIRNESS) &&
                         (req_thread[e*TID_W +: TID_W] == top_thread);
      end
   endgenerate

   always_comb begin
      active = '0;
      for (int i = 0; i < BUF_DEPTH; i++)
         if (req_valid[i]) active[req_thread[i*TID_W +: TID_W]] = 1'b1;
   end

   fda_stall_tracker #(.NUM_THREADS(NUM_THREADS), .STALL_W(STALL_W)) u_track (
      .clk(clk), .rst_n(rst_n), .stall(thread_stall), .active(active),
      .shared_flat(shared_flat));

   fda_slowdown_cmp #(.NUM_THREADS(NUM_THREADS), .STALL_W(STALL_W), .ALONE_W(ALONE_W),
                      .THR_W(THR_W), .THR_FRAC(THR_FRAC)) u_cmp (
      .shared_flat(shared_flat), .alone_flat(alone_est), .active(active),
      .thresh(unfair_thresh), .mode(mode), .top_thread(top_thread));

   fda_grant_select #(.DEPTH(BUF_DEPTH), .AGE_W(AGE_W)) u_sel (
      .valid(req_valid), .pri(pri), .hit(hit), .age_flat(req_age),
      .gnt_valid(gnt_valid), .gnt_idx(gnt_idx));

   assign fair_mode = (mode == FDA_FAIRNESS);
endmodule

// File: rtl/fda_arbiter_checker.sv
module fda_arbiter_checker #(
   parameter int NUM_THREADS = 4,
   parameter int BUF_DEPTH   = 8,
   parameter int NUM_BANKS   = 4,
   parameter int ROW_W       = 8,
   parameter int STALL_W     = 16,
   localparam int TID_W      = $clog2(NUM_THREADS),
   localparam int IDX_W      = $clog2(BUF_DEPTH),
   localparam int BANK_W     = $clog2(NUM_BANKS)
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [BUF_DEPTH-1:0]           req_valid,
   input logic [BUF_DEPTH*TID_W-1:0]     req_thread,
   input logic [BUF_DEPTH*BANK_W-1:0]    req_bank,
   input logic [BUF_DEPTH*ROW_W-1:0]     req_row,
   input logic [NUM_BANKS*ROW_W-1:0]     open_row,
   input logic                           gnt_valid,
   input logic [IDX_W-1:0]               gnt_idx,
   input logic                           fair_mode,
   input logic [TID_W-1:0]               top_thread,
   input logic [NUM_THREADS*STALL_W-1:0] shared_flat
);
   logic [BUF_DEPTH-1:0] hit_c;
   logic                 top_has;
   logic [TID_W-1:0]     g_thr;

   always_comb begin
      top_has = 1'b0;
      for (int i = 0; i < BUF_DEPTH; i++) begin
         hit_c[i] = req_row[i*ROW_W +: ROW_W] ==
                    open_row[req_bank[i*BANK_W +: BANK_W]*ROW_W +: ROW_W];
         if (req_valid[i] && req_thread[i*TID_W +: TID_W] == top_thread) top_has = 1'b1;
      end
      g_thr = req_thread[gnt_idx*TID_W +: TID_W];
   end

   assert_idle_no_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_valid) |-> !gnt_valid);
   assert_busy_grants_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_valid) |-> (gnt_valid && req_valid[gnt_idx]));
   assert_hit_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fair_mode && (|(hit_c & req_valid))) |-> hit_c[gnt_idx]);
   assert_top_thread_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fair_mode |-> (g_thr == top_thread));
   assert_top_thread_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fair_mode |-> top_has);

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_mono
         assert_counter_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (shared_flat[t*STALL_W +: STALL_W] >=
                      $past(shared_flat[t*STALL_W +: STALL_W])));
      end
   endgenerate
endmodule

bind fair_dram_arbiter fda_arbiter_checker #(
   .NUM_THREADS(NUM_THREADS), .BUF_DEPTH(BUF_DEPTH), .NUM_BANKS(NUM_BANKS),
   .ROW_W(ROW_W), .STALL_W(STALL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_thread(req_thread),
   .req_bank(req_bank), .req_row(req_row), .open_row(open_row),
   .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .fair_mode(fair_mode),
   .top_thread(top_thread), .shared_flat(shared_flat)
);

// File: tb/fair_dram_arbiter_test.sv
`timescale 1ns/1ps
module fair_dram_arbiter_test;
   localparam int T = 4, D = 8, B = 4, ROW_W = 8, AGE_W = 8;
   localparam int ALONE_W = 12, THR_W = 8;
   localparam int TID_W = 2, IDX_W = 3, BANK_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [D-1:0]         req_valid;
   logic [D*TID_W-1:0]   req_thread;
   logic [D*BANK_W-1:0]  req_bank;
   logic [D*ROW_W-1:0]   req_row;
   logic [D*AGE_W-1:0]   req_age;
   logic [B*ROW_W-1:0]   open_row;
   logic [T-1:0]         thread_stall;
   logic [T*ALONE_W-1:0] alone_est;
   logic [THR_W-1:0]     unfair_thresh;
   logic                 gnt_valid, fair_mode;
   logic [IDX_W-1:0]     gnt_idx;
   logic [TID_W-1:0]     top_thread;

   fair_dram_arbiter uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_thread(req_thread),
      .req_bank(req_bank), .req_row(req_row), .req_age(req_age), .open_row(open_row),
      .thread_stall(thread_stall), .alone_est(alone_est), .unfair_thresh(unfair_thresh),
      .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .fair_mode(fair_mode),
      .top_thread(top_thread));

   int e_v[D], e_t[D], e_b[D], e_r[D], e_a[D];
   int orow[B], stl[T], aln[T], thr;
   longint sh[T];

   typedef struct { bit gv; int gi; bit fm; int tt; string tag; } exp_t;
   exp_t q[$];
   int checks = 0, fails = 0;
   bit done = 0;

   task automatic drive();
      for (int i = 0; i < D; i++) begin
         req_valid[i] = e_v[i] != 0;
         req_thread[i*TID_W +: TID_W] = TID_W'(e_t[i]);
         req_bank[i*BANK_W +: BANK_W] = BANK_W'(e_b[i]);
         req_row[i*ROW_W +: ROW_W]    = ROW_W'(e_r[i]);
         req_age[i*AGE_W +: AGE_W]    = AGE_W'(e_a[i]);
      end
      for (int b = 0; b < B; b++) open_row[b*ROW_W +: ROW_W] = ROW_W'(orow[b]);
      for (int t = 0; t < T; t++) begin
         thread_stall[t] = stl[t] != 0;
         alone_est[t*ALONE_W +: ALONE_W] = ALONE_W'(aln[t]);
      end
      unfair_thresh = THR_W'(thr);
   endtask

   function automatic bit is_active(int t);
      for (int i = 0; i < D; i++) if (e_v[i] != 0 && e_t[i] == t) return 1;
      return 0;
   endfunction

   // Reference ordering built from R3..R8
   function automatic exp_t model(string tag);
      exp_t x;
      longint a[T];
      bit found = 0;
      int mx = 0, mn = 0;
      int bk = 0;
      for (int t = 0; t < T; t++) a[t] = (aln[t] == 0) ? 1 : aln[t];
      for (int t = 0; t < T; t++) begin
         if (is_active(t)) begin
            if (!found) begin found = 1; mx = t; mn = t; end
            else begin
               if (sh[t]*a[mx] > sh[mx]*a[t]) mx = t;
               if (sh[t]*a[mn] < sh[mn]*a[t]) mn = t;
            end
         end
      end
      x.fm = found && sh[mx] != 0 && (sh[mx]*a[mn]*16 >= longint'(thr)*a[mx]*sh[mn]);
      x.tt = mx;
      x.gv = 0; x.gi = 0;
      for (int i = 0; i < D; i++) begin
         if (e_v[i] != 0) begin
            int k;
            k = ((x.fm && e_t[i] == mx) ? 1024 : 0) + ((e_r[i] == orow[e_b[i]]) ? 512 : 0) + e_a[i];
            if (!x.gv || k > bk) begin x.gv = 1; x.gi = i; bk = k; end
         end
      end
      x.tag = tag;
      return x;
   endfunction

   task automatic apply(string tag);
      drive();
      q.push_back(model(tag));
      @(posedge clk);
      if (rst_n) begin
         for (int t = 0; t < T; t++)
            if (stl[t] != 0 && is_active(t) && sh[t] < 65535) sh[t]++;
      end
      @(negedge clk);
   endtask

   task automatic clear_entries();
      for (int i = 0; i < D; i++) begin e_v[i] = 0; e_t[i] = 0; e_b[i] = 0; e_r[i] = 0; e_a[i] = 0; end
   endtask

   task automatic put(int i, int th, int bk, int rw, int ag);
      e_v[i] = 1; e_t[i] = th; e_b[i] = bk; e_r[i] = rw; e_a[i] = ag;
   endtask

   // Monitor: compares each expected item against the outputs away from the edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (gnt_valid !== e.gv || (e.gv && int'(gnt_idx) != e.gi) ||
                fair_mode !== e.fm || int'(top_thread) != e.tt) begin
               fails++;
               $display("FAIL %s: got gv=%0b idx=%0d fair=%0b top=%0d, expected gv=%0b idx=%0d fair=%0b top=%0d",
                        e.tag, gnt_valid, gnt_idx, fair_mode, top_thread, e.gv, e.gi, e.fm, e.tt);
            end
         end
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R1: got hung run, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      clear_entries();
      for (int t = 0; t < T; t++) begin stl[t] = 0; aln[t] = 10; sh[t] = 0; end
      orow[0] = 3; orow[1] = 7; orow[2] = 0; orow[3] = 0;
      thr = 24;
      drive();
      @(negedge clk);
      // R10: stalls during reset must not count
      put(1, 1, 1, 9, 0); stl[1] = 1;
      apply("R10");
      apply("R10");
      stl[1] = 0;
      clear_entries();
      rst_n = 1'b1;
      apply("R1");                                    // empty buffer
      put(0, 0, 0, 5, 50); put(3, 1, 1, 7, 2);
      apply("R4");                                    // young hit beats old miss
      put(1, 2, 0, 3, 10); put(2, 3, 1, 7, 20);
      apply("R4");                                    // oldest hit wins -> 2
      e_a[1] = 20;
      apply("R8");                                    // equal hits -> slot 1
      clear_entries();
      put(4, 0, 2, 9, 7); put(6, 0, 2, 9, 7);
      apply("R8");                                    // equal misses -> slot 4
      // R2: accumulate shared stall: thread1 12 cycles, thread0 4 cycles
      clear_entries();
      put(0, 0, 0, 5, 1); put(1, 1, 1, 9, 1);
      for (int c = 0; c < 12; c++) begin
         stl[1] = 1; stl[0] = (c < 4) ? 1 : 0;
         apply("R2");
      end
      stl[0] = 0; stl[1] = 0;
      // R5: ratio 3.0 > 1.5, thread1 first, then its hit
      clear_entries();
      put(0, 0, 0, 3, 90); put(1, 1, 1, 9, 1);
      apply("R5");
      put(5, 1, 1, 7, 0);
      apply("R5");
      // R9 / R6: threshold changes take effect in the same cycle
      thr = 255; apply("R9");
      thr = 48;  apply("R6");                          // ratio equals threshold
      thr = 49;  apply("R6");
      thr = 24;
      // R2: stall without queued request is not counted
      aln[2] = 1; stl[2] = 1;
      for (int c = 0; c < 30; c++) apply("R2");
      stl[2] = 0;
      put(2, 2, 3, 9, 0);
      apply("R2");
      // R3: inactive thread drops out
      e_v[1] = 0; e_v[5] = 0;
      apply("R3");
      // R7: zero alone estimate taken as one
      clear_entries();
      aln[0] = 0; aln[1] = 1; aln[2] = 10;
      put(0, 0, 2, 9, 0); put(1, 1, 2, 9, 0);
      apply("R7");
      // R10: reset clears counters, back to hit-first
      rst_n = 1'b0;
      apply("R10");
      for (int t = 0; t < T; t++) sh[t] = 0;
      rst_n = 1'b1;
      clear_entries();
      put(0, 0, 0, 3, 0); put(1, 1, 1, 9, 50);
      apply("R10");
      // R6: mixed traffic
      for (int c = 0; c < 400; c++) begin
         if (c % 40 == 0) begin
            int pick;
            pick = $urandom_range(0, 3);
            thr = (pick == 0) ? 16 : (pick == 1) ? 20 : (pick == 2) ? 24 : 40;
         end
         for (int i = 0; i < D; i++) begin
            e_v[i] = ($urandom_range(0, 3) != 0) ? 1 : 0;
            e_t[i] = $urandom_range(0, T-1);
            e_b[i] = $urandom_range(0, B-1);
            e_r[i] = $urandom_range(0, 3);
            e_a[i] = $urandom_range(0, 15);
         end
         for (int b = 0; b < B; b++) orow[b] = $urandom_range(0, 3);
         for (int t = 0; t < T; t++) begin
            stl[t] = ($urandom_range(0, 1 + t) != 0) ? 1 : 0;
            aln[t] = $urandom_range(0, 15);
         end
         apply("R6");
      end
      @(negedge clk);
      #2;
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule